// File: doc/BRIEF.md
# Detection-Window Peak Classifier

This block sits behind a bank of per-neuron matched filters. On every sampling strobe it receives one signed discriminant score per neuron. The block decides when a spike event begins and ends, and reports which neuron produced the strongest score during that event. An event opens on the first strobe where any score is strictly positive. While the event is open, the block keeps the largest score seen and the lane that produced it.

The event lasts at least a configurable number of samples. Once that minimum is reached, the event ends on the first strobe where no score is positive. At that point the block issues a one-cycle report carrying the winning neuron index and its peak score. The block then returns to idle, and the very next strobe may open a fresh event.

Top module: `dwm_classifier`

## Requirements
- R1: While reset is low, and after reset until the first event closes, `rpt_vld` is 0. After reset, `rpt_id` and `rpt_peak` read 0.
- R2: A strobe whose scores are all zero or negative does not open an event. A score of exactly 0 never counts as positive.
- R3: The reported `rpt_id` is the lane index of the largest score seen on any strobe of the event. `rpt_peak` is that score as a 13-bit two's-complement value.
- R4: When several lanes share the largest score on one strobe, the lowest lane index wins.
- R5: When a later strobe only equals the running maximum, the earlier holder is kept.
- R6: Samples are counted from 1, and the opening strobe is sample 1. The event cannot close before sample number `min_len`. It closes on the first strobe n with n >= `min_len` on which every score is <= 0.
- R7: After the minimum length is reached, the event stays open for as long as any score is positive on a strobe.
- R8: `rpt_vld` is high for exactly one clock, on the cycle after the clock edge that samples the closing strobe. Lane i occupies bits `disc_vec[i*13 +: 13]`.
- R9: A strobe that immediately follows a closing strobe opens a new event if any of its scores is positive.
- R10: A `min_len` of 0 or 1 behaves like 2: the event closes on the first non-positive strobe after the opening one.
- R11: Clock cycles with `sample_vld` low leave the event state unchanged and produce no report, whatever `disc_vec` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Strobe marking one sampling cycle of scores |
| disc_vec | input | NUM_NEURONS*DISC_W (104) | Packed signed scores, lane i at bits i*DISC_W upward |
| min_len | input | LEN_W (8) | Minimum event length in samples |
| rpt_vld | output | 1 | One-cycle report pulse |
| rpt_id | output | ID_W (3) | Winning lane index |
| rpt_peak | output | DISC_W (13) | Peak score of the winning lane, signed |

## Verification
Single positive strobes followed by quiet strobes show whether the minimum length is honoured, as opposed to closing on the first quiet sample. Long positive runs show whether the event stretches past the minimum. Equal scores within one strobe, and across strobes, show which tie order is applied. A closing strobe followed directly by a positive strobe shows that no idle gap is inserted between events. Random scores between strobes, gaps of varying length, and random score vectors at full signed range compare every report against a bench model built from the requirements, including the extreme values -4096 and 4095.

// File: rtl/dwm_pkg.sv
// Shared definitions for the detection-window peak classifier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dwm_pkg;

    // Event state: idle between events, open while an event is tracked.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    // Index width for a lane count, never below one bit.
    function automatic int idx_width(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/dwm_peak_scan.sv
// Combinational scan over one strobe of packed signed scores.
// Finds the largest score and its lane; on equal scores the lowest lane wins.
// Also flags whether any lane is strictly positive.
// Assumes lane i occupies bits [i*LANE_W +: LANE_W], two's complement.
module dwm_peak_scan #(
    parameter int NUM_LANES = 8,
    parameter int LANE_W    = 13,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_LANES*LANE_W-1:0] lanes_flat,
    output logic signed [LANE_W-1:0]    peak_val,
    output logic [IDX_W-1:0]            peak_idx,
    output logic                        any_pos
);

    logic signed [LANE_W-1:0] lane_val [NUM_LANES];
    logic [NUM_LANES-1:0]     lane_pos;

    // Unpack each lane and flag it when strictly positive.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_val[g] = $signed(lanes_flat[g*LANE_W +: LANE_W]);
        assign lane_pos[g] = !lane_val[g][LANE_W-1] && (lane_val[g] != '0);
    end

    assign any_pos = |lane_pos;

    // Linear argmax; a strict compare keeps the lower lane on equal values.
    always_comb begin
        peak_val = lane_val[0];
        peak_idx = '0;
        for (int i = 1; i < NUM_LANES; i++) begin
            if (lane_val[i] > peak_val) begin
                peak_val = lane_val[i];
                peak_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dwm_window_ctrl.sv
// Event window controller.
// Opens on a strobe with a positive score and counts the samples in the event.
// Closes on the first strobe that is at least min_len samples into the event
// and has no positive score. The sample counter saturates, so very long events
// stay closable. Cycles without a strobe leave the state unchanged.
module dwm_window_ctrl
    import dwm_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             any_pos,
    input  logic [LEN_W-1:0] min_len,
    output logic             open_now,
    output logic             close_now,
    output logic             in_win
);

    win_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_inc;

    // Sample number of the current strobe if it belongs to the open event.
    assign cnt_inc   = {1'b0, cnt_q} + (LEN_W+1)'(1);
    assign in_win    = (state_q == WIN_OPEN);
    assign open_now  = strobe && !in_win && any_pos;
    assign close_now = strobe && in_win && !any_pos
                       && (cnt_inc >= {1'b0, min_len});

    // State and sample counter update on strobes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
        end else if (open_now) begin
            state_q <= WIN_OPEN;
            cnt_q   <= LEN_W'(1);
        end else if (close_now) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
        end else if (strobe && in_win && (cnt_q != '1)) begin
            cnt_q   <= cnt_q + LEN_W'(1);
        end
    end

endmodule

// File: rtl/dwm_best_track.sv
// Running-maximum register for one event.
// Loads on the opening strobe. Later strobes replace the stored value only
// when strictly larger, so the earliest holder of a maximum is kept.
module dwm_best_track #(
    parameter int VAL_W = 13,
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    upd_en,
    input  logic signed [VAL_W-1:0] cand_val,
    input  logic [IDX_W-1:0]        cand_idx,
    output logic signed [VAL_W-1:0] best_val,
    output logic [IDX_W-1:0]        best_idx
);

    // Capture the first candidate, then keep only strict improvements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_val <= '0;
            best_idx <= '0;
        end else if (load || (upd_en && (cand_val > best_val))) begin
            best_val <= cand_val;
            best_idx <= cand_idx;
        end
    end

endmodule

// File: rtl/dwm_classifier.sv
// Detection-window peak classifier, top level.
// Scans the score vector on each strobe, runs the event window, tracks the
// peak and registers a one-cycle report when the event closes.
// Assumes scores are two's complement, packed lane by lane.
module dwm_classifier #(
    parameter  int NUM_NEURONS = 8,
    parameter  int DISC_W      = 13,
    parameter  int LEN_W       = 8,
    localparam int ID_W        = dwm_pkg::idx_width(NUM_NEURONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_vld,
    input  logic [NUM_NEURONS*DISC_W-1:0] disc_vec,
    input  logic [LEN_W-1:0]              min_len,
    output logic                          rpt_vld,
    output logic [ID_W-1:0]               rpt_id,
    output logic signed [DISC_W-1:0]      rpt_peak
);

    logic signed [DISC_W-1:0] scan_val;
    logic [ID_W-1:0]          scan_idx;
    logic                     scan_pos;
    logic                     open_now;
    logic                     close_now;
    logic                     in_win;
    logic signed [DISC_W-1:0] best_val;
    logic [ID_W-1:0]          best_idx;

    dwm_peak_scan #(
        .NUM_LANES (NUM_NEURONS),
        .LANE_W    (DISC_W),
        .IDX_W     (ID_W)
    ) u_scan (
        .lanes_flat (disc_vec),
        .peak_val   (scan_val),
        .peak_idx   (scan_idx),
        .any_pos    (scan_pos)
    );

    dwm_window_ctrl #(
        .LEN_W (LEN_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (sample_vld),
        .any_pos   (scan_pos),
        .min_len   (min_len),
        .open_now  (open_now),
        .close_now (close_now),
        .in_win    (in_win)
    );

    dwm_best_track #(
        .VAL_W (DISC_W),
        .IDX_W (ID_W)
    ) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (open_now),
        .upd_en   (sample_vld && in_win),
        .cand_val (scan_val),
        .cand_idx (scan_idx),
        .best_val (best_val),
        .best_idx (best_idx)
    );

    // Report register: pulse for one cycle with the event winner on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_vld  <= 1'b0;
            rpt_id   <= '0;
            rpt_peak <= '0;
        end else begin
            rpt_vld <= close_now;
            if (close_now) begin
                rpt_id   <= best_idx;
                rpt_peak <= best_val;
            end
        end
    end

endmodule

// File: rtl/dwm_classifier_chk.sv
// Assertion checker for dwm_classifier, attached by bind below.
// Observes ports only.
module dwm_classifier_chk #(
    parameter int NUM_NEURONS = 8,
    parameter int DISC_W      = 13
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sample_vld,
    input logic [NUM_NEURONS*DISC_W-1:0] disc_vec,
    input logic                          rpt_vld,
    input logic signed [DISC_W-1:0]      rpt_peak
);

    logic [NUM_NEURONS-1:0] pos_lane;
    logic                   any_pos_in;

    // Independent positive detection per lane, taken from the input port.
    for (genvar g = 0; g < NUM_NEURONS; g++) begin : g_pos
        assign pos_lane[g] = !disc_vec[g*DISC_W + DISC_W - 1]
                             && (disc_vec[g*DISC_W +: DISC_W] != '0);
    end
    assign any_pos_in = |pos_lane;

    // R8
    rpt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |=> !rpt_vld);

    // R11
    rpt_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> $past(sample_vld));

    // R6
    rpt_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> !$past(any_pos_in));

    // R3
    rpt_peak_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> (!rpt_peak[DISC_W-1] && (rpt_peak != '0)));

endmodule

bind dwm_classifier dwm_classifier_chk #(
    .NUM_NEURONS (NUM_NEURONS),
    .DISC_W      (DISC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .disc_vec   (disc_vec),
    .rpt_vld    (rpt_vld),
    .rpt_peak   (rpt_peak)
);

// File: tb/tb_dwm_classifier.sv
`timescale 1ns/1ps
module tb_dwm_classifier;

    localparam int NN   = 8;
    localparam int DW   = 13;
    localparam int LW   = 8;
    localparam int IW   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_vld = 1'b0;
    logic [NN*DW-1:0]     disc_vec = '0;
    logic [LW-1:0]        min_len = LW'(10);
    logic                 rpt_vld;
    logic [IW-1:0]        rpt_id;
    logic signed [DW-1:0] rpt_peak;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    int cur [NN];
    int ml_cur = 10;
    bit m_open = 0;
    int m_cnt = 0;
    int m_best = 0;
    int m_idx = 0;

    always #2.5 clk = ~clk;

    dwm_classifier dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .disc_vec   (disc_vec),
        .min_len    (min_len),
        .rpt_vld    (rpt_vld),
        .rpt_id     (rpt_id),
        .rpt_peak   (rpt_peak)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic pack_cur();
        for (int i = 0; i < NN; i++) disc_vec[i*DW +: DW] = DW'(cur[i]);
    endtask

    task automatic set_all(input int v);
        for (int i = 0; i < NN; i++) cur[i] = v;
    endtask

    // One strobe: drive, advance the model, check the report one clock later.
    task automatic do_sample(input string tag);
        bit anyp = 0;
        int mx = cur[0];
        int mi = 0;
        bit ev = 0;
        int eid = 0;
        int epk = 0;
        for (int i = 0; i < NN; i++) if (cur[i] > 0) anyp = 1;
        for (int i = 1; i < NN; i++) if (cur[i] > mx) begin mx = cur[i]; mi = i; end
        if (!m_open) begin
            if (anyp) begin m_open = 1; m_cnt = 1; m_best = mx; m_idx = mi; end
        end else begin
            if (!anyp && (m_cnt + 1 >= ml_cur)) begin
                ev = 1; eid = m_idx; epk = m_best; m_open = 0;
            end else begin
                m_cnt++;
                if (mx > m_best) begin m_best = mx; m_idx = mi; end
            end
        end
        @(negedge clk);
        pack_cur();
        min_len = LW'(ml_cur);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        check(rpt_vld == ev, tag, "rpt_vld", int'(rpt_vld), int'(ev));
        if (ev && rpt_vld) begin
            check(int'(rpt_id) == eid, tag, "rpt_id", int'(rpt_id), eid);
            check(int'(rpt_peak) == epk, tag, "rpt_peak", int'(rpt_peak), epk);
        end
    endtask

    // Idle cycles with random scores; no report may appear (R11, R8).
    task automatic do_gap(input int n);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < NN; i++)
                disc_vec[i*DW +: DW] = DW'($urandom_range(8191));
            @(negedge clk);
            check(rpt_vld == 1'b0, "R11", "rpt_vld in gap", int'(rpt_vld), 0);
        end
    endtask

    function automatic int rnd_score(input bit allow_pos);
        if (allow_pos) return int'($urandom_range(8191)) - 4096;
        return -int'($urandom_range(4096));
    endfunction

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        check(rpt_vld == 1'b0, "R1", "rpt_vld in reset", int'(rpt_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rpt_vld == 1'b0, "R1", "rpt_vld after reset", int'(rpt_vld), 0);
        check(rpt_id == '0, "R1", "rpt_id after reset", int'(rpt_id), 0);
        check(rpt_peak == '0, "R1", "rpt_peak after reset", int'(rpt_peak), 0);

        // R2: zeros and negatives never open an event
        set_all(0); do_sample("R2");
        set_all(-5); cur[3] = 0; do_sample("R2");
        set_all(0); do_sample("R2");

        // R6: single positive strobe, min length 10
        ml_cur = 10;
        set_all(-3); cur[5] = 40; do_sample("R6");
        set_all(0);
        for (int s = 0; s < 9; s++) do_sample("R6");

        // R7: positive run well past the minimum
        ml_cur = 3;
        for (int s = 0; s < 6; s++) begin
            set_all(-1); cur[s % NN] = 10 + s; do_sample("R7");
        end
        set_all(0); do_sample("R7");

        // R4: equal maxima within one strobe
        ml_cur = 2;
        set_all(1); cur[2] = 77; cur[6] = 77; do_sample("R4");
        set_all(-9); do_sample("R4");

        // R5: equal maxima across strobes keep the earlier holder
        set_all(0); cur[6] = 55; do_sample("R5");
        set_all(0); cur[1] = 55; do_sample("R5");
        set_all(0); do_sample("R5");

        // R9: new event right after a closing strobe
        set_all(0); cur[0] = 9; do_sample("R9");
        set_all(0); do_sample("R9");
        set_all(0); cur[7] = 4095; cur[4] = 12; do_sample("R9");
        set_all(-4096); do_sample("R9");

        // R10: min length 0 and 1
        ml_cur = 0;
        set_all(0); cur[3] = 1; do_sample("R10");
        set_all(0); do_sample("R10");
        ml_cur = 1;
        set_all(-4096); cur[2] = 2; do_sample("R10");
        set_all(-4096); do_sample("R10");

        // R11: gaps with random scores do not disturb an open event
        ml_cur = 4;
        set_all(-2); cur[4] = 100; do_sample("R11");
        do_gap(5);
        set_all(-2); do_sample("R11");
        do_gap(3);
        set_all(-2); do_sample("R11");
        set_all(-2); do_sample("R11");

        // R3: constrained random events with random gaps
        for (int w = 0; w < 120; w++) begin
            ml_cur = int'($urandom_range(12));
            for (int s = 0; s < 16; s++) begin
                bit act = ($urandom_range(99) < 45);
                for (int i = 0; i < NN; i++)
                    cur[i] = rnd_score(act && ($urandom_range(3) == 0));
                do_sample("R3");
                if ($urandom_range(3) == 0) do_gap(int'($urandom_range(3)));
            end
        end
        // drain any open event
        set_all(0);
        for (int s = 0; s < 14; s++) do_sample("R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule